// File: doc/BRIEF.md
# Indexed Capability Table Peripheral

This peripheral lets software discover what the hardware it runs on can do. It sits on a 16-bit word-addressed CPU bus and exposes two adjacent registers. The first is a selector that software writes with the number of the entry it wants, and it can read the selector back. The second is a read-only window that returns the entry the selector currently picks.

The table is sparse and split into two groups. The scalar group starts at index 0x0000 and holds sizes and rates. The flag group starts at 0x0100 and holds one presence bit per optional unit. Every value is fixed at build time through parameters, so one netlist serves many targets.

Platform identifiers keep the board family in bits [7:4] and the revision in bits [3:0]. Software that only cares about the family masks off the low nibble.

Top module: `sysinfo_window`

## Requirements
- R1: After reset the selector holds 0x0000, so a read of the selector address (BASE_ADDR, default 0xFFE8) returns 0x0000 and a read of the window (BASE_ADDR+1) returns the platform identifier.
- R2: A bus write to BASE_ADDR loads the written word into the selector. Every later read of BASE_ADDR returns the last word written.
- R3: A read of BASE_ADDR+1 with the selector in 0x0000..0x0007 returns the scalar entries in this order: platform identifier (default 0x0012), clock in MHz (50), register bank count (256), RAM start word address (0x8000), RAM size in kilo-words (32), sprite count (128), screen buffer lines (800), UART top rate in kb/s (1000).
- R4: A read of BASE_ADDR+1 with the selector in 0x0100..0x0104 returns 0x0001 when the unit is present and 0x0000 when it is absent. The order is memory management unit (default absent), extended arithmetic unit (present), floating point unit (absent), VGA output (present), keyboard (present).
- R5: A read of BASE_ADDR+1 with the selector on any index outside the two defined ranges returns 0x0000.
- R6: The window output is combinational on the selector. A window read in the clock cycle right after a selector write returns the entry for the new index.
- R7: A bus write to BASE_ADDR+1, or to any address outside the window, changes no state. The selector keeps its value.
- R8: busRdData is 0x0000 whenever busRdEn is low or busAddr is neither BASE_ADDR nor BASE_ADDR+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Word address of the current access |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busRdEn | input | 1 | Read strobe, data returned in the same cycle |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, zero when not selected |

## Verification
The assertions assume that busWrEn and busRdEn are never high together. They also assume that the bus inputs are stable around each rising edge, and that reads have no side effects, so a read strobe held over several cycles is harmless. The stimulus drives only single-cycle accesses that are changed on the falling edge, and it never raises both strobes at once. Random selector values are biased toward the two defined ranges and their edges, while the remaining values are spread over the whole 16-bit space. This gives the undefined-index path steady coverage.

// File: rtl/sysinfo_pkg.sv
package sysinfo_pkg;

  localparam int WORD_W = 16;

  // Group numbers sit in the upper byte of the selector.
  localparam logic [7:0] GROUP_SCALAR = 8'h00;
  localparam logic [7:0] GROUP_FLAG   = 8'h01;

  localparam int SCALAR_CNT = 8;
  localparam int FLAG_CNT   = 5;
  localparam int SCALAR_SEL_W = $clog2(SCALAR_CNT);
  localparam int FLAG_SEL_W   = $clog2(FLAG_CNT);

  typedef struct packed {
    logic loadIndex;   // write selector
    logic readIndex;   // drive selector onto read bus
    logic readEntry;   // drive table entry onto read bus
  } sysinfoStrobes_t;

endpackage

// File: rtl/sysinfo_ctrl.sv
module sysinfo_ctrl
  import sysinfo_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'hFFE8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [15:0]     busAddr,
  input  logic            busWrEn,
  input  logic            busRdEn,
  output sysinfoStrobes_t strobes
);

  localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd1;

  logic hitIndex;
  logic hitData;

  assign hitIndex = (busAddr == BASE_ADDR);
  assign hitData  = (busAddr == DATA_ADDR);

  always_comb begin
    strobes           = '0;
    // Writes to the data address are dropped on purpose.
    strobes.loadIndex = busWrEn & hitIndex;
    strobes.readIndex = busRdEn & hitIndex;
    strobes.readEntry = busRdEn & hitData;
  end

  // R8: at most one read source, and no read source without a read strobe
  a_r8_one_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.readIndex, strobes.readEntry}));

  a_r8_no_source_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> !(strobes.readIndex | strobes.readEntry));

  // R7: no selector load without a write to the selector address
  a_r7_no_stray_load: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != BASE_ADDR) |-> !strobes.loadIndex);

endmodule

// File: rtl/sysinfo_dpath.sv
module sysinfo_dpath
  import sysinfo_pkg::*;
#(
  parameter logic [15:0] PLATFORM_ID = 16'h0012,
  parameter logic [15:0] CLK_MHZ     = 16'd50,
  parameter logic [15:0] BANK_COUNT  = 16'd256,
  parameter logic [15:0] RAM_START   = 16'h8000,
  parameter logic [15:0] RAM_KWORDS  = 16'd32,
  parameter logic [15:0] SPRITE_CNT  = 16'd128,
  parameter logic [15:0] SCREEN_ROWS = 16'd800,
  parameter logic [15:0] UART_KBPS   = 16'd1000,
  parameter bit          HAS_MMU     = 1'b0,
  parameter bit          HAS_EAE     = 1'b1,
  parameter bit          HAS_FPU     = 1'b0,
  parameter bit          HAS_VGA     = 1'b1,
  parameter bit          HAS_KBD     = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sysinfoStrobes_t   strobes,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);

  localparam int FLAG_SLOTS = 2 ** FLAG_SEL_W;

  logic [WORD_W-1:0] indexQ;
  logic [WORD_W-1:0] entry;
  logic [WORD_W-1:0] scalarTab [SCALAR_CNT];
  logic [FLAG_SLOTS-1:0] flagVec;
  logic [7:0] groupSel;
  logic [7:0] slotSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ <= '0;
    end else if (strobes.loadIndex) begin
      indexQ <= wrData;
    end
  end

  always_comb begin
    scalarTab[0] = PLATFORM_ID;
    scalarTab[1] = CLK_MHZ;
    scalarTab[2] = BANK_COUNT;
    scalarTab[3] = RAM_START;
    scalarTab[4] = RAM_KWORDS;
    scalarTab[5] = SPRITE_CNT;
    scalarTab[6] = SCREEN_ROWS;
    scalarTab[7] = UART_KBPS;
  end

  // Pad the flag vector to a power of two; the padding slots read as absent.
  generate
    for (genvar g = 0; g < FLAG_SLOTS; g++) begin : g_flag
      if (g == 0)      begin : g_mmu assign flagVec[g] = HAS_MMU; end
      else if (g == 1) begin : g_eae assign flagVec[g] = HAS_EAE; end
      else if (g == 2) begin : g_fpu assign flagVec[g] = HAS_FPU; end
      else if (g == 3) begin : g_vga assign flagVec[g] = HAS_VGA; end
      else if (g == 4) begin : g_kbd assign flagVec[g] = HAS_KBD; end
      else             begin : g_pad assign flagVec[g] = 1'b0;    end
    end
  endgenerate

  assign groupSel = indexQ[15:8];
  assign slotSel  = indexQ[7:0];

  always_comb begin
    entry = '0;
    if (groupSel == GROUP_SCALAR && slotSel < 8'(SCALAR_CNT)) begin
      entry = scalarTab[slotSel[SCALAR_SEL_W-1:0]];
    end else if (groupSel == GROUP_FLAG && slotSel < 8'(FLAG_CNT)) begin
      entry = {{(WORD_W-1){1'b0}}, flagVec[slotSel[FLAG_SEL_W-1:0]]};
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.readIndex) begin
      rdData = indexQ;
    end else if (strobes.readEntry) begin
      rdData = entry;
    end
  end

  // R2: a load strobe puts the write word into the selector
  a_r2_index_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadIndex |=> indexQ == $past(wrData));

  // R7: without a load strobe the selector holds
  a_r7_index_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadIndex |=> $stable(indexQ));

  // R5: an upper byte above the flag group always yields zero
  a_r5_undef_zero: assert property (@(posedge clk) disable iff (!rstN)
    (indexQ[15:9] != 7'd0) |-> entry == '0);

  // R4: flag entries carry at most one set bit, in bit 0
  a_r4_flag_shape: assert property (@(posedge clk) disable iff (!rstN)
    (groupSel == GROUP_FLAG) |-> (entry[WORD_W-1:1] == '0));

endmodule

// File: rtl/sysinfo_window.sv
module sysinfo_window
  import sysinfo_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR   = 16'hFFE8,
  parameter logic [15:0] PLATFORM_ID = 16'h0012,
  parameter logic [15:0] CLK_MHZ     = 16'd50,
  parameter logic [15:0] BANK_COUNT  = 16'd256,
  parameter logic [15:0] RAM_START   = 16'h8000,
  parameter logic [15:0] RAM_KWORDS  = 16'd32,
  parameter logic [15:0] SPRITE_CNT  = 16'd128,
  parameter logic [15:0] SCREEN_ROWS = 16'd800,
  parameter logic [15:0] UART_KBPS   = 16'd1000,
  parameter bit          HAS_MMU     = 1'b0,
  parameter bit          HAS_EAE     = 1'b1,
  parameter bit          HAS_FPU     = 1'b0,
  parameter bit          HAS_VGA     = 1'b1,
  parameter bit          HAS_KBD     = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData
);

  sysinfoStrobes_t strobes;

  sysinfo_ctrl #(
    .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  sysinfo_dpath #(
    .PLATFORM_ID (PLATFORM_ID),
    .CLK_MHZ     (CLK_MHZ),
    .BANK_COUNT  (BANK_COUNT),
    .RAM_START   (RAM_START),
    .RAM_KWORDS  (RAM_KWORDS),
    .SPRITE_CNT  (SPRITE_CNT),
    .SCREEN_ROWS (SCREEN_ROWS),
    .UART_KBPS   (UART_KBPS),
    .HAS_MMU     (HAS_MMU),
    .HAS_EAE     (HAS_EAE),
    .HAS_FPU     (HAS_FPU),
    .HAS_VGA     (HAS_VGA),
    .HAS_KBD     (HAS_KBD)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWrData),
    .rdData  (busRdData)
  );

  // R8: quiet read bus when no read is issued
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> busRdData == 16'h0000);

endmodule

// File: tb/sysinfo_window_tb.sv
module sysinfo_window_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDX_ADDR = 16'hFFE8;
  localparam logic [15:0] DAT_ADDR = 16'hFFE9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;

  int checks = 0;
  int fails  = 0;
  logic [15:0] modelIdx = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysinfo_window u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busWrData (busWrData),
    .busRdData (busRdData)
  );

  function automatic logic [15:0] expEntry(input logic [15:0] idx);
    case (idx)
      16'h0000: return 16'h0012;
      16'h0001: return 16'd50;
      16'h0002: return 16'd256;
      16'h0003: return 16'h8000;
      16'h0004: return 16'd32;
      16'h0005: return 16'd128;
      16'h0006: return 16'd800;
      16'h0007: return 16'd1000;
      16'h0100: return 16'h0000;
      16'h0101: return 16'h0001;
      16'h0102: return 16'h0000;
      16'h0103: return 16'h0001;
      16'h0104: return 16'h0001;
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic string reqOf(input logic [15:0] idx);
    if (idx <= 16'h0007) return "R3";
    if (idx >= 16'h0100 && idx <= 16'h0104) return "R4";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // Inputs change on the falling edge; a write lands on the next rising edge.
  task automatic busWrite(input logic [15:0] addr, input logic [15:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1; busRdEn = 1'b0;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 16'h0000;
  endtask

  // Read data is combinational: sample shortly after driving.
  task automatic busRead(input logic [15:0] addr, output logic [15:0] data);
    busAddr = addr; busRdEn = 1'b1; busWrEn = 1'b0;
    #1;
    data = busRdData;
    @(negedge clk);
    busRdEn = 1'b0; busAddr = 16'h0000;
  endtask

  task automatic readData(input string req);
    logic [15:0] d;
    busRead(DAT_ADDR, d);
    check(req, d, expEntry(modelIdx));
  endtask

  task automatic readIndex(input string req);
    logic [15:0] d;
    busRead(IDX_ADDR, d);
    check(req, d, modelIdx);
  endtask

  function automatic logic [15:0] pickIndex();
    int sel = int'($urandom_range(0, 5));
    case (sel)
      0: return 16'($urandom_range(0, 9));
      1: return 16'($urandom_range(16'h00FE, 16'h0106));
      2: return 16'h0100 | 16'($urandom_range(0, 7));
      3: return 16'($urandom_range(16'hFF00, 16'hFFFF));
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readIndex("R1");
    readData("R1");

    // R3 every scalar entry, R6 read right after each write
    for (int i = 0; i < 8; i++) begin
      busWrite(IDX_ADDR, 16'(i)); modelIdx = 16'(i);
      readData("R3_R6");
      readIndex("R2");
    end
    // R4 every flag
    for (int i = 0; i < 5; i++) begin
      busWrite(IDX_ADDR, 16'h0100 + 16'(i)); modelIdx = 16'h0100 + 16'(i);
      readData("R4");
    end
    // R5 boundaries
    busWrite(IDX_ADDR, 16'h0008); modelIdx = 16'h0008; readData("R5");
    busWrite(IDX_ADDR, 16'h0105); modelIdx = 16'h0105; readData("R5");
    busWrite(IDX_ADDR, 16'h00FF); modelIdx = 16'h00FF; readData("R5");
    busWrite(IDX_ADDR, 16'hFFFF); modelIdx = 16'hFFFF; readIndex("R2"); readData("R5");

    // R7 write to data address ignored
    busWrite(IDX_ADDR, 16'h0003); modelIdx = 16'h0003;
    busWrite(DAT_ADDR, 16'h0101);
    readIndex("R7"); readData("R7");
    busWrite(16'hFFEA, 16'h0005);
    readIndex("R7");

    // R8 idle and out-of-window reads
    #1; check("R8", busRdData, 16'h0000);
    busRead(16'hFFE7, d); check("R8", d, 16'h0000);
    busRead(16'hFFEA, d); check("R8", d, 16'h0000);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom_range(0, 4));
      case (op)
        0: begin
          logic [15:0] v = pickIndex();
          busWrite(IDX_ADDR, v); modelIdx = v;
          readData(reqOf(v));
        end
        1: readIndex("R2");
        2: readData(reqOf(modelIdx));
        3: begin
          busWrite(DAT_ADDR, 16'($urandom));
          readIndex("R7");
        end
        default: begin
          logic [15:0] a = 16'($urandom);
          if (a == IDX_ADDR || a == DAT_ADDR) a = 16'h1234;
          busRead(a, d); check("R8", d, 16'h0000);
        end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule